// File: doc/BRIEF.md
# Quad Hardware Stack Unit

A single 256-word register file is divided into four separate 64-word stacks. An 8-bit stack pointer selects the location: bits [7:6] pick the stack and bits [5:0] pick the word inside it. In each enabled cycle the unit reads or writes one word and moves the in-stack index by a signed step taken from a 4-bit instruction field. The step can range from -8 to +7, so a single operation can push, pop, or skip several words.

Writes go to the pointer value after the step and reads come from the value before it. With a step of +1 for a write and -1 for a read, this gives a pre-increment push and a post-decrement pop. The stack-select bits never move during a step, so the index wraps inside its own 64-word window. A step that crosses that window's top or bottom sets a sticky error flag for the stack concerned. A direct pointer load replaces the step for the cycle.

Top module: `quad_stack_unit`

## Requirements
- R1: After reset `sp` is 0x00, `rd_data` is 0 and every bit of `ovf_flags` and `unf_flags` is 0.
- R2: When `op_en`=1 and `ptr_ld`=0, the next `sp[5:0]` is (sp[5:0] + adj) mod 64, where `adj_fld` is a 4-bit two's-complement value from -8 to +7. `sp[7:6]` stays unchanged.
- R3: When `op_en`=1 and `op_wr`=0, `rd_data` after the clock edge equals the word stored at the pointer value from before the edge, that is, before the step. `rd_data` holds its value in every cycle without a read.
- R4: When `op_en`=1 and `op_wr`=1, `wr_data` is stored at the pointer value after the step.
- R5: When sp[5:0] + adj exceeds 63 on a step, bit sp[7:6] of `ovf_flags` is set.
- R6: When sp[5:0] + adj is below 0 on a step, bit sp[7:6] of `unf_flags` is set.
- R7: Flag bits are sticky until reset. A step sets at most the flag of the selected stack and never touches the flags of the other stacks.
- R8: When `ptr_ld`=1, `sp` becomes `ptr_ld_val` on the next edge and no step is applied. A read or write enabled in the same cycle uses the current pointer, and no flag changes.
- R9: When `op_en`=0 and `ptr_ld`=0, the pointer, the memory, the flags and `rd_data` all stay unchanged, whatever `op_wr`, `adj_fld` and `wr_data` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_en | input | 1 | Perform a memory access and a pointer step this cycle |
| op_wr | input | 1 | 1 = write, 0 = read |
| adj_fld | input | 4 | Signed pointer step, -8..+7 |
| wr_data | input | 16 | Word to store |
| ptr_ld | input | 1 | Load the pointer directly |
| ptr_ld_val | input | 8 | Value for a pointer load |
| rd_data | output | 16 | Registered read word |
| sp | output | 8 | Current stack pointer |
| ovf_flags | output | 4 | Sticky overflow flag per stack |
| unf_flags | output | 4 | Sticky underflow flag per stack |

## Verification
The hardest case to reach is a step that crosses a window boundary while the other stacks' flags must stay clear. The pointer normally moves by small steps, so the bench first uses a direct load to place it a few words from the edge of one stack. It then applies a large positive or negative step and checks three things: the wrapped index, the unchanged select bits, and that exactly one flag bit is set. The load-with-access cycle is also covered: a write issued together with a load is read back later to show where it landed.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int STK_DATA_W = 16;
    localparam int STK_COUNT  = 4;
    localparam int STK_DEPTH  = 64;
    localparam int STK_ADJ_W  = 4;
endpackage

// File: rtl/stk_ptr_calc.sv
module stk_ptr_calc #(
    parameter int SEL_W = 2,
    parameter int IDX_W = 6,
    parameter int ADJ_W = 4,
    localparam int PTR_W = SEL_W + IDX_W
) (
    input  logic [PTR_W-1:0] ptr,
    input  logic [ADJ_W-1:0] adj,
    output logic [PTR_W-1:0] ptr_step,
    output logic             ovf_hit,
    output logic             unf_hit
);
    localparam int SUM_W = IDX_W + 2;

    logic signed [SUM_W-1:0] idx_ext;
    logic signed [SUM_W-1:0] adj_ext;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        idx_ext  = $signed({2'b00, ptr[IDX_W-1:0]});
        adj_ext  = $signed({{(SUM_W-ADJ_W){adj[ADJ_W-1]}}, adj});
        sum      = idx_ext + adj_ext;
        unf_hit  = sum[SUM_W-1];
        ovf_hit  = !sum[SUM_W-1] && sum[IDX_W];
        ptr_step = {ptr[PTR_W-1:IDX_W], sum[IDX_W-1:0]};
    end
endmodule

// File: rtl/stk_flag_bank.sv
module stk_flag_bank #(
    parameter int COUNT = 4,
    localparam int SEL_W = $clog2(COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_en,
    input  logic [SEL_W-1:0] sel,
    input  logic             ovf_hit,
    input  logic             unf_hit,
    output logic [COUNT-1:0] ovf_q,
    output logic [COUNT-1:0] unf_q
);
    typedef struct packed {
        logic [COUNT-1:0] ovf;
        logic [COUNT-1:0] unf;
    } flags_t;

    flags_t flags_d, flags_q;

    for (genvar g = 0; g < COUNT; g++) begin : g_stack
        always_comb begin
            flags_d.ovf[g] = flags_q.ovf[g] | (chk_en && (sel == SEL_W'(g)) && ovf_hit);
            flags_d.unf[g] = flags_q.unf[g] | (chk_en && (sel == SEL_W'(g)) && unf_hit);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign ovf_q = flags_q.ovf;
    assign unf_q = flags_q.unf;

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));
    a_r7_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((unf_q & $past(unf_q)) == $past(unf_q)));
    a_r7_one_stack: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones({ovf_q ^ $past(ovf_q), unf_q ^ $past(unf_q)}) <= 1));
endmodule

// File: rtl/stk_ram.sv
module stk_ram #(
    parameter int DATA_W = 16,
    parameter int WORDS  = 256,
    localparam int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) rdata_d = mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = rdata_q;

    a_r3_hold_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/quad_stack_unit.sv
module quad_stack_unit #(
    parameter int DATA_W = stk_pkg::STK_DATA_W,
    parameter int COUNT  = stk_pkg::STK_COUNT,
    parameter int DEPTH  = stk_pkg::STK_DEPTH,
    parameter int ADJ_W  = stk_pkg::STK_ADJ_W,
    localparam int SEL_W = $clog2(COUNT),
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = SEL_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_en,
    input  logic              op_wr,
    input  logic [ADJ_W-1:0]  adj_fld,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ptr_ld,
    input  logic [PTR_W-1:0]  ptr_ld_val,
    output logic [DATA_W-1:0] rd_data,
    output logic [PTR_W-1:0]  sp,
    output logic [COUNT-1:0]  ovf_flags,
    output logic [COUNT-1:0]  unf_flags
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } core_t;

    core_t core_d, core_q;

    logic [PTR_W-1:0] ptr_step;
    logic             ovf_hit, unf_hit;
    logic             step_en;
    logic [PTR_W-1:0] wr_addr;

    stk_ptr_calc #(.SEL_W(SEL_W), .IDX_W(IDX_W), .ADJ_W(ADJ_W)) u_calc (
        .ptr      (core_q.ptr),
        .adj      (adj_fld),
        .ptr_step (ptr_step),
        .ovf_hit  (ovf_hit),
        .unf_hit  (unf_hit)
    );

    always_comb begin
        core_d  = core_q;
        step_en = op_en && !ptr_ld;
        wr_addr = ptr_ld ? core_q.ptr : ptr_step;
        if (ptr_ld)       core_d.ptr = ptr_ld_val;
        else if (op_en)   core_d.ptr = ptr_step;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    stk_flag_bank #(.COUNT(COUNT)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .chk_en  (step_en),
        .sel     (core_q.ptr[PTR_W-1:IDX_W]),
        .ovf_hit (ovf_hit),
        .unf_hit (unf_hit),
        .ovf_q   (ovf_flags),
        .unf_q   (unf_flags)
    );

    stk_ram #(.DATA_W(DATA_W), .WORDS(COUNT*DEPTH)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (op_en && !op_wr),
        .rd_addr (core_q.ptr),
        .wr_en   (op_en && op_wr),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    assign sp = core_q.ptr;

    a_r2_sel_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && !ptr_ld) |=> (sp[PTR_W-1:IDX_W] == $past(sp[PTR_W-1:IDX_W])));
    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_ld |=> (sp == $past(ptr_ld_val)));
    a_r8_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_ld |=> ($stable(ovf_flags) && $stable(unf_flags)));
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_en && !ptr_ld) |=> ($stable(sp) && $stable(ovf_flags) && $stable(unf_flags)));
endmodule

// File: tb/quad_stack_unit_bench.sv
module quad_stack_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_en = 1'b0, op_wr = 1'b0, ptr_ld = 1'b0;
    logic [3:0]  adj_fld = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  ptr_ld_val = '0;
    logic [15:0] rd_data;
    logic [7:0]  sp;
    logic [3:0]  ovf_flags, unf_flags;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    logic [15:0] mem_m [256];
    logic [7:0]  sp_m;
    logic [15:0] rd_m;
    logic [3:0]  ovf_m, unf_m;

    always #10 clk = ~clk;

    quad_stack_unit u_quad_stack_unit (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_wr(op_wr),
        .adj_fld(adj_fld), .wr_data(wr_data), .ptr_ld(ptr_ld),
        .ptr_ld_val(ptr_ld_val), .rd_data(rd_data), .sp(sp),
        .ovf_flags(ovf_flags), .unf_flags(unf_flags)
    );

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk(req, "sp", {8'h00, sp}, {8'h00, sp_m});
        chk(req, "rd_data", rd_data, rd_m);
        chk(req, "ovf", {12'h0, ovf_flags}, {12'h0, ovf_m});
        chk(req, "unf", {12'h0, unf_flags}, {12'h0, unf_m});
    endtask

    // one cycle: drive at negedge, model, sample at next negedge
    task automatic op(string req, bit en, bit wr, int adj, logic [15:0] wd, bit ld, logic [7:0] ldv);
        int s;
        logic [7:0] wa;
        @(negedge clk);
        op_en = en; op_wr = wr; adj_fld = 4'(adj); wr_data = wd;
        ptr_ld = ld; ptr_ld_val = ldv;
        s  = int'(sp_m[5:0]) + adj;
        wa = sp_m;
        if (en && !wr) rd_m = mem_m[sp_m];
        if (ld) begin
            sp_m = ldv;
        end else if (en) begin
            wa = {sp_m[7:6], 6'(s)};
            if (s > 63) ovf_m[sp_m[7:6]] = 1'b1;
            if (s < 0)  unf_m[sp_m[7:6]] = 1'b1;
            sp_m = wa;
        end
        if (en && wr) mem_m[wa] = wd;
        @(negedge clk);
        op_en = 1'b0; ptr_ld = 1'b0;
        check_all(req);
    endtask

    task automatic t_reset();
        sp_m = 8'h00; rd_m = 16'h0; ovf_m = '0; unf_m = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");
    endtask

    task automatic t_push_pop();
        op("R8", 0, 0, 0, 0, 1, 8'h40);
        for (int i = 0; i < 5; i++) op("R4", 1, 1, 1, 16'hA000 + 16'(i), 0, 0);
        for (int i = 0; i < 5; i++) op("R3", 1, 0, -1, 0, 0, 0);
        op("R2", 1, 0, 7, 0, 0, 0);
        op("R2", 1, 0, -8, 0, 0, 0);
    endtask

    task automatic t_multi_step();
        op("R8", 0, 0, 0, 0, 1, 8'h10);
        op("R4", 1, 1, 5, 16'h1515, 0, 0);   // stored at 0x15
        op("R4", 1, 1, -3, 16'h1212, 0, 0);  // stored at 0x12
        op("R3", 1, 0, 3, 0, 0, 0);          // reads 0x12
        op("R3", 1, 0, 0, 0, 0, 0);          // reads 0x15
    endtask

    task automatic t_overflow();
        op("R8", 0, 0, 0, 0, 1, 8'hBE);
        op("R5", 1, 1, 3, 16'hBEEF, 0, 0);   // wraps to 0x81
        op("R7", 1, 0, 0, 0, 0, 0);          // flag remains, reads 0x81
    endtask

    task automatic t_underflow();
        op("R8", 0, 0, 0, 0, 1, 8'hC1);
        op("R6", 1, 0, -4, 0, 0, 0);         // wraps to 0xFD
        op("R7", 1, 1, 1, 16'h7777, 0, 0);
        op("R7", 1, 0, -1, 0, 0, 0);
    endtask

    task automatic t_load_override();
        op("R8", 0, 0, 0, 0, 1, 8'h20);
        op("R8", 1, 1, 5, 16'h5A5A, 1, 8'h7F); // write lands at 0x20
        op("R8", 1, 0, 7, 0, 1, 8'h20);        // read old ptr 0x7F (unwritten? no: read at 0x7F)
    endtask

    task automatic t_idle();
        op("R8", 0, 0, 0, 0, 1, 8'h30);
        op("R4", 1, 1, 0, 16'h3030, 0, 0);
        op("R9", 0, 1, 4, 16'hDEAD, 0, 0);
        op("R9", 0, 0, -5, 16'hDEAD, 0, 0);
        op("R9", 1, 0, 0, 0, 0, 0);            // 0x30 still holds 3030
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_m[i] = 16'hxxxx;
        t_reset();
        t_push_pop();
        t_multi_step();
        t_overflow();
        // pre-fill 0x7F so the read in t_load_override is defined
        op("R4", 0, 0, 0, 0, 1, 8'h7E);
        op("R4", 1, 1, 1, 16'h7F7F, 0, 0);
        t_load_override();
        t_underflow();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule